// File: doc/BRIEF.md
# HDLC Receive Deframer with Address Filter

This block receives a synchronous serial bit stream, one bit per cycle in which the bit-clock enable is high. It hunts for the delimiter flag, deletes the zeros that a transmitter inserts after five consecutive ones, and assembles the remaining bits into octets with the earliest bit in the least significant position. Each frame's check sequence is verified, and the frame is filtered on an address field at its start. Octets that pass are delivered on a valid/last byte stream. The check-sequence octets are held back and never delivered.

When a frame ends, a one-cycle status pulse reports four things: a check-sequence error, an abort, a length error, and whether the address matched. Configuration inputs select the address length (none, one octet or two octets), the station address, and a 16-bit or 32-bit check sequence. Frames whose address matches neither the station address nor the all-ones broadcast value deliver no octets. Their status pulse shows the match bit clear.

The controller is a three-state machine. HUNT waits for a flag after reset or an abort. IDLE means a flag has been seen and no frame bits have arrived yet. DATA means frame bits are being collected. The transitions are:
- HUNT to IDLE on a flag.
- IDLE to DATA on the first frame bit.
- IDLE to HUNT on an abort.
- DATA to IDLE on a closing flag.
- DATA to HUNT on an abort.
- IDLE stays in IDLE on further flags.

Top module: `hdlc_rx_deframer`

## Requirements
- R1: Octets are collected only after a flag (bits 0,1,1,1,1,1,1,0 on the line). Bits before the first flag are ignored. Consecutive flags with no bits between them produce neither octets nor a status pulse.
- R2: A 0 that follows exactly five consecutive 1s is deleted from the data.
- R3: Each octet is assembled with the first received bit as bit 0 and the eighth as bit 7.
- R4: A seventh consecutive 1 inside a frame aborts it. The block gives a status pulse with `stat_abort`=1, does not assert `out_last`, and ignores the line until the next flag.
- R5: With `cfg_crc32`=0, the check runs over all frame bits, LSB first, using reflected polynomial 0x8408 and initial value 0xFFFF. A final register other than 0xF0B8 sets `stat_crc_err`. At most one of `stat_crc_err`, `stat_abort` and `stat_short` is set per status pulse.
- R6: With `cfg_crc32`=1, the check uses reflected polynomial 0xEDB88320 and initial value 0xFFFFFFFF, and the required final register is 0xDEBB20E3. The trailer is four octets instead of two.
- R7: The trailer octets are never delivered. The octet just before the trailer carries `out_last`=1, in the same cycle as the status pulse, for frames with no length error (including those with a check error).
- R8: `cfg_addr_len`=0 means no address field. Every frame is delivered and `stat_addr_match`=1.
- R9: `cfg_addr_len`=1 compares the first octet with `cfg_station[7:0]` or with 0xFF.
- R10: `cfg_addr_len`=2 forms the address from two octets, the first as the low byte and the second as the high byte. It is compared with `cfg_station` or with 0xFFFF.
- R11: A frame with a non-matching address delivers no octet. Its status pulse has `stat_addr_match`=0.
- R12: `stat_short`=1, with no `out_last`, is reported when either of these holds at the closing flag:
  - the frame has fewer octets than the larger of (address octets + trailer octets) and (trailer octets + 1);
  - the bit count is not a multiple of eight.
- R13: The line is sampled only in cycles with `bit_en`=1. Every output pulse lasts one cycle and follows such a cycle. After reset no pulse is given.
- R14: `cfg_addr_len`=3 behaves like 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bit_en | input | 1 | Bit-clock enable; `bit_in` is taken when high |
| bit_in | input | 1 | Serial line bit |
| cfg_addr_len | input | 2 | Address octets: 0 none, 1 one, 2 or 3 two |
| cfg_station | input | 16 | Station address |
| cfg_crc32 | input | 1 | 1 selects the 32-bit check, 0 the 16-bit check |
| out_valid | output | 1 | Delivered octet strobe |
| out_data | output | 8 | Delivered octet |
| out_last | output | 1 | Final delivered octet of a frame |
| stat_valid | output | 1 | Frame-end status strobe |
| stat_crc_err | output | 1 | Check sequence wrong |
| stat_abort | output | 1 | Frame aborted |
| stat_short | output | 1 | Length error |
| stat_addr_match | output | 1 | Address matched (or no address field) |

## Verification
At the closing flag, two functions coincide in one cycle:
- delivery of the last data octet, pulled from the hold-back line;
- the frame status pulse.

This coincidence is provoked with good frames and with frames corrupted by one bit. The bench samples both strobes at the same falling edge and requires the last-marked octet to be the final expected byte, together with exactly one status pulse carrying the expected error bits. Aborts and length errors are also provoked at that moment, to show that the status pulse then arrives without any last octet. Address mismatch is checked the same way, to show that the status pulse comes with no delivery.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;

    typedef enum logic [1:0] {
        ST_HUNT = 2'd0,
        ST_IDLE = 2'd1,
        ST_DATA = 2'd2
    } rx_state_e;

    localparam int OCT_W         = 8;
    localparam int FCS_MAX_BYTES = 4;
    localparam int GUARD_BITS    = 7;   // leading zero plus six ones of a flag
    localparam int RUN_W         = 3;

    localparam logic [15:0] POLY16 = 16'h8408;
    localparam logic [31:0] POLY32 = 32'hEDB88320;
    localparam logic [15:0] GOOD16 = 16'hF0B8;
    localparam logic [31:0] GOOD32 = 32'hDEBB20E3;

endpackage

// File: rtl/hdlc_rx_linescan.sv
module hdlc_rx_linescan
    import hdlc_rx_pkg::*;
#(
    parameter int GUARD = GUARD_BITS
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_en,
    input  logic bit_in,
    output logic flag_ev,
    output logic abort_ev,
    output logic dbit_vld,
    output logic dbit
);
    localparam int GCNT_W = $clog2(GUARD + 1);

    logic [RUN_W-1:0]  run_q;
    logic [GUARD-1:0]  guard_q;
    logic [GCNT_W-1:0] gcnt_q;
    logic              stuffed, ones_idle, push;

    assign flag_ev   = bit_en && !bit_in && (run_q == RUN_W'(6));
    assign abort_ev  = bit_en &&  bit_in && (run_q == RUN_W'(6));
    assign stuffed   = bit_en && !bit_in && (run_q == RUN_W'(5));
    assign ones_idle = bit_in && (run_q == RUN_W'(7));
    assign push      = bit_en && !flag_ev && !abort_ev && !stuffed && !ones_idle;
    assign dbit_vld  = push && (gcnt_q == GCNT_W'(GUARD));
    assign dbit      = guard_q[GUARD-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q   <= '0;
            guard_q <= '0;
            gcnt_q  <= '0;
        end else if (bit_en) begin
            if (bit_in)
                run_q <= (run_q == RUN_W'(7)) ? run_q : run_q + RUN_W'(1);
            else
                run_q <= '0;
            if (flag_ev || abort_ev) begin
                gcnt_q <= '0;
            end else if (push) begin
                guard_q <= {guard_q[GUARD-2:0], bit_in};
                if (gcnt_q != GCNT_W'(GUARD))
                    gcnt_q <= gcnt_q + GCNT_W'(1);
            end
        end
    end
endmodule

// File: rtl/hdlc_rx_fcs.sv
module hdlc_rx_fcs
    import hdlc_rx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic en,
    input  logic din,
    input  logic wide,
    output logic good
);
    logic [31:0] acc_q;
    logic        fb;

    assign fb   = acc_q[0] ^ din;
    assign good = wide ? (acc_q == GOOD32) : (acc_q[15:0] == GOOD16);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '1;
        end else if (clr) begin
            acc_q <= '1;
        end else if (en) begin
            if (wide)
                acc_q <= (acc_q >> 1) ^ (fb ? POLY32 : 32'h0);
            else
                acc_q[15:0] <= (acc_q[15:0] >> 1) ^ (fb ? POLY16 : 16'h0);
        end
    end
endmodule

// File: rtl/hdlc_rx_addr_cmp.sv
module hdlc_rx_addr_cmp (
    input  logic [15:0] cand,
    input  logic [15:0] station,
    input  logic        wide,
    output logic        hit
);
    always_comb begin
        if (wide)
            hit = (cand == station) || (cand == 16'hFFFF);
        else
            hit = (cand[7:0] == station[7:0]) || (cand[7:0] == 8'hFF);
    end
endmodule

// File: rtl/hdlc_rx_deframer.sv
module hdlc_rx_deframer
    import hdlc_rx_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bit_en,
    input  logic        bit_in,
    input  logic [1:0]  cfg_addr_len,
    input  logic [15:0] cfg_station,
    input  logic        cfg_crc32,
    output logic        out_valid,
    output logic [7:0]  out_data,
    output logic        out_last,
    output logic        stat_valid,
    output logic        stat_crc_err,
    output logic        stat_abort,
    output logic        stat_short,
    output logic        stat_addr_match
);
    localparam int HOLD   = FCS_MAX_BYTES + 1;
    localparam int HIDX_W = $clog2(HOLD);
    localparam int BIT_W  = $clog2(OCT_W);

    rx_state_e state_q, state_d;

    logic              flag_ev, abort_ev, dbit_vld, dbit, fcs_good, addr_hit;
    logic              take_bit, byte_done, frame_clr, len_err;
    logic [OCT_W-1:0]  asm_q, new_byte, addr_lo_q;
    logic [BIT_W-1:0]  nbits_q;
    logic [CNT_W-1:0]  oct_cnt_q, emit_thr, len_thr;
    logic [OCT_W-1:0]  held_q [HOLD];
    logic [HIDX_W-1:0] fcs_bytes;
    logic [1:0]        adr_bytes;
    logic              addr_ok_q;
    logic [15:0]       addr_cand;

    hdlc_rx_linescan u_scan (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .bit_in(bit_in),
        .flag_ev(flag_ev), .abort_ev(abort_ev), .dbit_vld(dbit_vld), .dbit(dbit)
    );

    hdlc_rx_fcs u_fcs (
        .clk(clk), .rst_n(rst_n), .clr(frame_clr), .en(take_bit),
        .din(dbit), .wide(cfg_crc32), .good(fcs_good)
    );

    hdlc_rx_addr_cmp u_addr (
        .cand(addr_cand), .station(cfg_station),
        .wide(adr_bytes == 2'd2), .hit(addr_hit)
    );

    // configuration decode
    assign fcs_bytes = cfg_crc32 ? HIDX_W'(4) : HIDX_W'(2);
    assign adr_bytes = (cfg_addr_len == 2'd0) ? 2'd0 : (cfg_addr_len == 2'd1) ? 2'd1 : 2'd2;
    assign emit_thr  = CNT_W'(fcs_bytes) + CNT_W'(1);
    assign len_thr   = (adr_bytes == 2'd2) ? emit_thr + CNT_W'(1) : emit_thr;

    // bit and octet events
    assign frame_clr = flag_ev || abort_ev;
    assign take_bit  = dbit_vld && (state_q != ST_HUNT);
    assign byte_done = take_bit && (nbits_q == BIT_W'(OCT_W - 1));
    assign new_byte  = {dbit, asm_q[OCT_W-1:1]};
    assign addr_cand = (adr_bytes == 2'd2) ? {new_byte, addr_lo_q} : {8'h00, new_byte};
    assign len_err   = (nbits_q != '0) || (oct_cnt_q < len_thr);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HUNT;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HUNT: if (flag_ev) state_d = ST_IDLE;
            ST_IDLE: begin
                if (abort_ev)      state_d = ST_HUNT;
                else if (take_bit) state_d = ST_DATA;
            end
            ST_DATA: begin
                if (flag_ev)       state_d = ST_IDLE;
                else if (abort_ev) state_d = ST_HUNT;
            end
            default: state_d = ST_HUNT;
        endcase
    end

    // octet assembly, hold-back line and address capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            asm_q     <= '0;
            nbits_q   <= '0;
            oct_cnt_q <= '0;
            addr_lo_q <= '0;
            addr_ok_q <= 1'b0;
            for (int i = 0; i < HOLD; i++) held_q[i] <= '0;
        end else if (frame_clr) begin
            nbits_q   <= '0;
            oct_cnt_q <= '0;
            addr_ok_q <= (adr_bytes == 2'd0);
        end else if (take_bit) begin
            asm_q   <= new_byte;
            nbits_q <= nbits_q + BIT_W'(1);
            if (byte_done) begin
                for (int i = HOLD - 1; i > 0; i--) held_q[i] <= held_q[i-1];
                held_q[0] <= new_byte;
                if (oct_cnt_q != {CNT_W{1'b1}})
                    oct_cnt_q <= oct_cnt_q + CNT_W'(1);
                if (oct_cnt_q == '0) begin
                    addr_lo_q <= new_byte;
                    if (adr_bytes == 2'd1) addr_ok_q <= addr_hit;
                end
                if ((oct_cnt_q == CNT_W'(1)) && (adr_bytes == 2'd2))
                    addr_ok_q <= addr_hit;
            end
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid       <= 1'b0;
            out_data        <= '0;
            out_last        <= 1'b0;
            stat_valid      <= 1'b0;
            stat_crc_err    <= 1'b0;
            stat_abort      <= 1'b0;
            stat_short      <= 1'b0;
            stat_addr_match <= 1'b0;
        end else begin
            out_valid  <= 1'b0;
            out_last   <= 1'b0;
            stat_valid <= 1'b0;
            unique case (state_q)
                ST_HUNT, ST_IDLE: ;
                ST_DATA: begin
                    if (flag_ev) begin
                        stat_valid      <= 1'b1;
                        stat_short      <= len_err;
                        stat_crc_err    <= !len_err && !fcs_good;
                        stat_abort      <= 1'b0;
                        stat_addr_match <= addr_ok_q;
                        if (!len_err && addr_ok_q) begin
                            out_valid <= 1'b1;
                            out_last  <= 1'b1;
                            out_data  <= held_q[fcs_bytes];
                        end
                    end else if (abort_ev) begin
                        stat_valid      <= 1'b1;
                        stat_abort      <= 1'b1;
                        stat_short      <= 1'b0;
                        stat_crc_err    <= 1'b0;
                        stat_addr_match <= addr_ok_q;
                    end else if (byte_done && (oct_cnt_q >= emit_thr) && addr_ok_q) begin
                        out_valid <= 1'b1;
                        out_data  <= held_q[fcs_bytes];
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/hdlc_rx_deframer_chk.sv
module hdlc_rx_deframer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       bit_en,
    input logic       out_valid,
    input logic       out_last,
    input logic       stat_valid,
    input logic       stat_crc_err,
    input logic       stat_abort,
    input logic       stat_short,
    input logic       stat_addr_match
);
    // R7: the last octet is a delivered octet and coincides with a clean status pulse
    assert_last_is_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_valid);
    assert_last_with_status_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> (stat_valid && !stat_short && !stat_abort));

    // R12 and R4: a length error or abort never delivers an octet in that cycle
    assert_error_no_data_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_valid && (stat_short || stat_abort)) |-> !out_valid);

    // R5: error kinds are exclusive
    assert_one_error_kind_R5: assert property (@(posedge clk) disable iff (!rst_n)
        stat_valid |-> $onehot0({stat_crc_err, stat_abort, stat_short}));

    // R11: a rejected address never delivers with its status
    assert_mismatch_silent_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_valid && !stat_addr_match) |-> !out_valid);

    // R13: pulses follow a sampled bit and last one cycle
    assert_pulse_after_enable_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid || stat_valid) |-> $past(bit_en));
    assert_status_one_cycle_R13: assert property (@(posedge clk) disable iff (!rst_n)
        stat_valid |=> !stat_valid);
endmodule

bind hdlc_rx_deframer hdlc_rx_deframer_chk u_chk (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en),
    .out_valid(out_valid), .out_last(out_last),
    .stat_valid(stat_valid), .stat_crc_err(stat_crc_err),
    .stat_abort(stat_abort), .stat_short(stat_short),
    .stat_addr_match(stat_addr_match)
);

// File: tb/hdlc_rx_deframer_test.sv
module hdlc_rx_deframer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bit_en = 1'b0;
    logic        bit_in = 1'b1;
    logic [1:0]  cfg_addr_len = 2'd0;
    logic [15:0] cfg_station = 16'h0000;
    logic        cfg_crc32 = 1'b0;
    logic        out_valid, out_last, stat_valid;
    logic [7:0]  out_data;
    logic        stat_crc_err, stat_abort, stat_short, stat_addr_match;

    int vectors = 0;
    int miscompares = 0;
    bit done = 0;
    int tx_ones = 0;

    logic [7:0] frm[$];
    logic [7:0] exp_q[$];
    logic [7:0] rx_q[$];
    int         last_cnt, last_idx, stat_cnt;
    logic [3:0] stat_seen;

    always #10 clk = ~clk;

    hdlc_rx_deframer uut (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .bit_in(bit_in),
        .cfg_addr_len(cfg_addr_len), .cfg_station(cfg_station), .cfg_crc32(cfg_crc32),
        .out_valid(out_valid), .out_data(out_data), .out_last(out_last),
        .stat_valid(stat_valid), .stat_crc_err(stat_crc_err), .stat_abort(stat_abort),
        .stat_short(stat_short), .stat_addr_match(stat_addr_match)
    );

    // output monitor, sampled on the falling edge
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            rx_q.push_back(out_data);
            if (out_last) begin
                last_cnt++;
                last_idx = rx_q.size() - 1;
            end
        end
        if (rst_n && stat_valid) begin
            stat_cnt++;
            stat_seen = {stat_crc_err, stat_abort, stat_short, stat_addr_match};
        end
    end

    task automatic check(input string tag, input int got, input int exp);
        vectors++;
        if (got != exp) begin
            miscompares++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic clear_mon();
        rx_q.delete();
        last_cnt = 0;
        last_idx = -1;
        stat_cnt = 0;
        stat_seen = 4'h0;
    endtask

    // one line bit: enable for one cycle, then a cycle with junk on bit_in
    task automatic send_bit(input logic b);
        @(negedge clk);
        bit_in = b;
        bit_en = 1'b1;
        @(negedge clk);
        bit_en = 1'b0;
        bit_in = ~b;
    endtask

    task automatic send_flag();
        send_bit(0);
        for (int i = 0; i < 6; i++) send_bit(1);
        send_bit(0);
        tx_ones = 0;
    endtask

    task automatic send_data_bit(input logic b);
        send_bit(b);
        if (b) begin
            tx_ones++;
            if (tx_ones == 5) begin
                send_bit(0);
                tx_ones = 0;
            end
        end else begin
            tx_ones = 0;
        end
    endtask

    task automatic send_octet(input logic [7:0] v);
        for (int j = 0; j < 8; j++) send_data_bit(v[j]);
    endtask

    function automatic logic [31:0] calc_fcs(input bit wide);
        logic [31:0] c;
        logic        fb;
        c = wide ? 32'hFFFF_FFFF : 32'h0000_FFFF;
        foreach (frm[i]) begin
            for (int j = 0; j < 8; j++) begin
                fb = c[0] ^ frm[i][j];
                if (wide) c = (c >> 1) ^ (fb ? 32'hEDB88320 : 32'h0);
                else      c[15:0] = (c[15:0] >> 1) ^ (fb ? 16'h8408 : 16'h0);
            end
        end
        return ~c;
    endfunction

    // flag, body of frm, trailer, flag; flip_bit >= 0 corrupts one body bit
    task automatic send_frame(input bit wide, input int flip_bit);
        logic [31:0] f;
        logic [7:0]  b;
        f = calc_fcs(wide);
        send_flag();
        foreach (frm[i]) begin
            b = frm[i];
            if (flip_bit >= 0 && (flip_bit / 8) == i) b[flip_bit % 8] = ~b[flip_bit % 8];
            send_octet(b);
        end
        for (int k = 0; k < (wide ? 4 : 2); k++) send_octet(f[8*k +: 8]);
        send_flag();
        repeat (3) @(negedge clk);
    endtask

    task automatic expect_bytes(input string tag);
        check({tag, " count"}, rx_q.size(), exp_q.size());
        foreach (exp_q[i])
            if (i < rx_q.size()) check({tag, " octet"}, rx_q[i], exp_q[i]);
        check({tag, " R7 last count"}, last_cnt, exp_q.size() > 0 ? 1 : 0);
        if (exp_q.size() > 0) check({tag, " R7 last position"}, last_idx, exp_q.size() - 1);
    endtask

    // exp = {crc_err, abort, short, addr_match}
    task automatic expect_stat(input string tag, input logic [3:0] exp);
        check({tag, " R13 one status pulse"}, stat_cnt, 1);
        check({tag, " status"}, stat_seen, exp);
    endtask

    task automatic t_reset();
        check("R13 reset out_valid", out_valid, 0);
        check("R13 reset stat_valid", stat_valid, 0);
    endtask

    task automatic t_hunt_basic();
        cfg_addr_len = 2'd0; cfg_crc32 = 1'b0;
        clear_mon();
        // junk before any flag: R1
        send_bit(1); send_bit(0); send_bit(1); send_bit(1);
        send_bit(0); send_bit(0); send_bit(1); send_bit(0);
        check("R1 no output before first flag", rx_q.size() + stat_cnt, 0);
        frm = '{8'h12, 8'h34, 8'hA6};
        exp_q = frm;
        send_frame(0, -1);
        expect_bytes("R3 R7 R8 basic");
        expect_stat("R5 R8 basic", 4'b0001);
    endtask

    task automatic t_stuffing();
        cfg_addr_len = 2'd0; cfg_crc32 = 1'b0;
        clear_mon();
        frm = '{8'hFF, 8'h7E, 8'h1F, 8'hF8, 8'h3E};
        exp_q = frm;
        send_frame(0, -1);
        expect_bytes("R2 stuffed zeros");
        expect_stat("R2 stuffed zeros", 4'b0001);
    endtask

    task automatic t_crc_error();
        cfg_addr_len = 2'd0; cfg_crc32 = 1'b0;
        clear_mon();
        frm = '{8'h01, 8'h02, 8'h03, 8'h04};
        exp_q = '{8'h01, 8'h02, 8'h0B, 8'h04};
        send_frame(0, 19);
        expect_bytes("R5 corrupted");
        expect_stat("R5 corrupted", 4'b1001);
    endtask

    task automatic t_crc32_addr8();
        cfg_addr_len = 2'd1; cfg_crc32 = 1'b1; cfg_station = 16'h005A;
        clear_mon();
        frm = '{8'h5A, 8'h01, 8'h02};
        exp_q = frm;
        send_frame(1, -1);
        expect_bytes("R6 R9 station");
        expect_stat("R6 R9 station", 4'b0001);
        clear_mon();
        frm = '{8'hFF, 8'hC3, 8'h81, 8'h7F};
        exp_q = frm;
        send_frame(1, -1);
        expect_bytes("R9 broadcast");
        expect_stat("R9 broadcast", 4'b0001);
        clear_mon();
        frm = '{8'h5A, 8'h01, 8'h02};
        exp_q = frm;
        send_frame(1, 9);
        exp_q = '{8'h5A, 8'h03, 8'h02};
        expect_bytes("R6 corrupted");
        expect_stat("R6 corrupted", 4'b1001);
    endtask

    task automatic t_addr_mismatch();
        cfg_addr_len = 2'd1; cfg_crc32 = 1'b1; cfg_station = 16'h005A;
        clear_mon();
        frm = '{8'h33, 8'h44, 8'h55, 8'h66};
        exp_q.delete();
        send_frame(1, -1);
        expect_bytes("R11 mismatch");
        expect_stat("R11 mismatch", 4'b0000);
    endtask

    task automatic t_addr16();
        cfg_addr_len = 2'd2; cfg_crc32 = 1'b0; cfg_station = 16'hBEEF;
        clear_mon();
        frm = '{8'hEF, 8'hBE, 8'h09};
        exp_q = frm;
        send_frame(0, -1);
        expect_bytes("R10 station");
        expect_stat("R10 station", 4'b0001);
        clear_mon();
        frm = '{8'hBE, 8'hEF, 8'h09};
        exp_q.delete();
        send_frame(0, -1);
        expect_bytes("R10 swapped order");
        expect_stat("R10 swapped order", 4'b0000);
        clear_mon();
        frm = '{8'hFF, 8'hFF, 8'h07};
        exp_q = frm;
        send_frame(0, -1);
        expect_bytes("R10 broadcast");
        expect_stat("R10 broadcast", 4'b0001);
        cfg_addr_len = 2'd3;
        clear_mon();
        frm = '{8'hEF, 8'hBE, 8'h0A};
        exp_q = frm;
        send_frame(0, -1);
        expect_bytes("R14 length code 3");
        expect_stat("R14 length code 3", 4'b0001);
        clear_mon();
        frm = '{8'hEF, 8'h00, 8'h0A};
        exp_q.delete();
        send_frame(0, -1);
        expect_bytes("R14 high byte differs");
        expect_stat("R14 high byte differs", 4'b0000);
    endtask

    task automatic t_abort();
        cfg_addr_len = 2'd0; cfg_crc32 = 1'b0;
        clear_mon();
        send_flag();
        send_octet(8'h11); send_octet(8'h22); send_octet(8'h33);
        for (int i = 0; i < 8; i++) send_bit(1);
        // bits after an abort and before a flag are ignored
        send_octet(8'h5C);
        repeat (3) @(negedge clk);
        exp_q.delete();
        expect_bytes("R4 abort");
        expect_stat("R4 abort", 4'b0101);
        clear_mon();
        frm = '{8'h21, 8'h43, 8'h65};
        exp_q = frm;
        send_frame(0, -1);
        expect_bytes("R4 recovery");
        expect_stat("R4 recovery", 4'b0001);
    endtask

    task automatic t_short();
        cfg_addr_len = 2'd0; cfg_crc32 = 1'b0;
        clear_mon();
        send_flag();
        send_octet(8'hAB); send_octet(8'hCD);
        send_flag();
        repeat (3) @(negedge clk);
        exp_q.delete();
        expect_bytes("R12 two octets");
        expect_stat("R12 two octets", 4'b0011);
        // bit count not a multiple of eight
        clear_mon();
        frm = '{8'h10, 8'h20, 8'h30};
        begin
            logic [31:0] f;
            f = calc_fcs(0);
            send_flag();
            foreach (frm[i]) send_octet(frm[i]);
            send_octet(f[7:0]); send_octet(f[15:8]);
            send_data_bit(1); send_data_bit(0); send_data_bit(1);
            send_flag();
            repeat (3) @(negedge clk);
        end
        check("R12 odd bits no last", last_cnt, 0);
        check("R12 odd bits status", stat_seen, 4'b0011);
        check("R12 odd bits one pulse", stat_cnt, 1);
        // 16-bit address needs four octets
        cfg_addr_len = 2'd2; cfg_station = 16'hBEEF;
        clear_mon();
        send_flag();
        send_octet(8'hEF); send_octet(8'hBE); send_octet(8'h00);
        send_flag();
        repeat (3) @(negedge clk);
        check("R12 addr16 three octets no last", last_cnt, 0);
        check("R12 addr16 three octets short", stat_seen[1], 1);
    endtask

    task automatic t_idle_flags();
        cfg_addr_len = 2'd0; cfg_crc32 = 1'b0;
        clear_mon();
        for (int i = 0; i < 5; i++) send_flag();
        repeat (3) @(negedge clk);
        check("R1 back-to-back flags silent", rx_q.size() + stat_cnt, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_hunt_basic();
        t_stuffing();
        t_crc_error();
        t_crc32_addr8();
        t_addr_mismatch();
        t_addr16();
        t_abort();
        t_short();
        t_idle_flags();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            vectors++;
            miscompares++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule